// File: doc/BRIEF.md
# SDRAM Command Protocol Checker

This block watches the command pins of an SDRAM channel. It does not drive them. On each rising clock edge where the clock enable is high, it decodes the command presented by chip select, RAS, CAS and WE. It keeps track of which of the banks hold an open row. It also runs a small set of cycle counters per bank, plus one counter for the whole channel. When a command breaks a bank-state rule or a minimum cycle gap, the block latches an error flag together with a code that says which rule was broken. It sits next to a memory controller, either in silicon or in a test harness, and reports the first protocol fault it sees.

Only the first fault is kept. The flag and code hold until a synchronous clear is pulsed. A per-bank open-row vector shows the bank state that the block has inferred. The inter-command minimums are parameters, counted in clock cycles where the clock enable is high: activate to column, activate to activate on another bank, close to refresh, and the burst length used for auto-precharge.

Top module: `sdram_cmd_mon`

## Requirements
- R1: A command is decoded only on an edge where cke_i is high and cs_ni is low. The encoding of {ras_ni,cas_ni,we_ni} is: 011 activate, 101 read, 100 write, 010 precharge, 001 refresh. The patterns 000, 110 and 111 have no effect.
- R2: On an edge with cs_ni high and cke_i high, no command is taken and no error is raised, but all bank counters advance.
- R3: On an edge with cke_i low, no command is taken, no error is raised, the counters hold, and open_o does not change.
- R4: An activate to a closed bank sets bit ba_i of open_o, where bit i is bank i, from the next cycle.
- R5: A precharge with a10_i high closes every bank. With a10_i low it closes only bank ba_i. A precharge to a bank that is already closed has no effect and does not restart that bank's close timer.
- R6: A read or write with a10_i high to an open bank closes that bank BL active edges later. Until then, a read or write to that bank raises code 1 and an activate to it raises code 2.
- R7: A read or write to a bank without an open row raises code 1 and leaves the bank state unchanged.
- R8: An activate to an open bank raises code 2 and leaves the bank state unchanged.
- R9: A refresh raises code 3 if any bank is open, or if fewer than TRP active edges have passed since any bank closed.
- R10: A read or write fewer than TRCD active edges after the activate of its bank raises code 4. The access still takes effect.
- R11: An activate fewer than TRRD active edges after an activate to a different bank raises code 5. Column commands one edge apart never raise an error.
- R12: err_o is sticky and code_o keeps the first error's code, which is never 0 while err_o is high. When clr_i is high at an edge, both are cleared, and a violation on that same edge is not recorded.
- R13: After reset, err_o is 0, code_o is 0 and open_o is all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Memory clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clr_i | input | 1 | Synchronous clear of the error flag and code |
| cke_i | input | 1 | Sampled clock enable |
| cs_ni | input | 1 | Chip select, active low |
| ras_ni | input | 1 | Row strobe, active low |
| cas_ni | input | 1 | Column strobe, active low |
| we_ni | input | 1 | Write enable, active low |
| ba_i | input | $clog2(NB) | Bank address |
| a10_i | input | 1 | Address bit 10: precharge scope or auto-precharge request |
| err_o | output | 1 | Sticky protocol error flag |
| code_o | output | 3 | Code of the first error: 0 none, 1 to 5 as in R6 to R11 |
| open_o | output | NB | Per-bank open-row status |

## Verification
The bench builds the block with its default parameters: four banks, TRCD 3, TRRD 2, TRP 3 and BL 4. These short windows make it cheap to place commands exactly on the minimum gap and one edge before it. They also let an auto-precharge finish within a few cycles, so a refresh can be aimed right at the end of the close window. Clock-enable-low stretches are placed inside an activate-to-read gap, which shows that frozen edges do not count toward the minimum.

// File: rtl/sdram_mon_pkg.sv
package sdram_mon_pkg;

  typedef enum logic [2:0] {
    CMD_NOP, CMD_ACT, CMD_RD, CMD_WR, CMD_PRE, CMD_REF, CMD_MRS, CMD_BST
  } cmd_e;

  typedef enum logic [2:0] {
    ERR_NONE       = 3'd0,
    ERR_COL_CLOSED = 3'd1,
    ERR_ACT_OPEN   = 3'd2,
    ERR_REF        = 3'd3,
    ERR_RCD        = 3'd4,
    ERR_RRD        = 3'd5
  } err_e;

  function automatic cmd_e decode_cmd(logic ras_n, logic cas_n, logic we_n);
    case ({ras_n, cas_n, we_n})
      3'b011:  return CMD_ACT;
      3'b101:  return CMD_RD;
      3'b100:  return CMD_WR;
      3'b010:  return CMD_PRE;
      3'b001:  return CMD_REF;
      3'b000:  return CMD_MRS;
      3'b110:  return CMD_BST;
      default: return CMD_NOP;
    endcase
  endfunction

  function automatic int max4(int a, int b, int c, int d);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/sdram_bank_trk.sv
module sdram_bank_trk #(
  parameter int TRCD = 3,
  parameter int TRP  = 3,
  parameter int BL   = 4,
  parameter int CW   = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic adv_i,
  input  logic act_i,
  input  logic col_i,
  input  logic ap_i,
  input  logic close_i,
  output logic open_o,
  output logic pend_o,
  output logic rcd_ok_o,
  output logic rp_ok_o
);

  logic          open_q, pend_q;
  logic [CW-1:0] rcd_q, rp_q, ap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      open_q <= 1'b0;
      pend_q <= 1'b0;
      rcd_q  <= '0;
      rp_q   <= '0;
      ap_q   <= '0;
    end else if (adv_i) begin
      if (rcd_q != '0) rcd_q <= rcd_q - 1'b1;
      if (rp_q != '0)  rp_q  <= rp_q - 1'b1;
      if (act_i) begin
        open_q <= 1'b1;
        rcd_q  <= CW'(TRCD - 1);
      end else if (close_i && open_q) begin
        open_q <= 1'b0;
        pend_q <= 1'b0;
        rp_q   <= CW'(TRP - 1);
      end else if (col_i && ap_i) begin
        pend_q <= 1'b1;
        ap_q   <= CW'(BL);
      end else if (pend_q) begin
        // burst ends: bank closes on its own
        if (ap_q == CW'(1)) begin
          open_q <= 1'b0;
          pend_q <= 1'b0;
          rp_q   <= CW'(TRP - 1);
        end else begin
          ap_q <= ap_q - 1'b1;
        end
      end
    end
  end

  assign open_o   = open_q;
  assign pend_o   = pend_q;
  assign rcd_ok_o = (rcd_q == '0);
  assign rp_ok_o  = (rp_q == '0);

endmodule

// File: rtl/sdram_rule_eval.sv
module sdram_rule_eval import sdram_mon_pkg::*; #(
  parameter int NB = 4,
  localparam int BA_W = $clog2(NB)
) (
  input  cmd_e            cmd_i,
  input  logic [BA_W-1:0] ba_i,
  input  logic [NB-1:0]   open_i,
  input  logic [NB-1:0]   pend_i,
  input  logic [NB-1:0]   rcd_ok_i,
  input  logic [NB-1:0]   rp_ok_i,
  input  logic            rrd_ok_i,
  output logic            viol_o,
  output err_e            code_o,
  output logic            act_ok_o,
  output logic            col_ok_o
);

  always_comb begin
    viol_o   = 1'b0;
    code_o   = ERR_NONE;
    act_ok_o = 1'b0;
    col_ok_o = 1'b0;
    case (cmd_i)
      CMD_ACT: begin
        if (open_i[ba_i]) begin
          viol_o = 1'b1;
          code_o = ERR_ACT_OPEN;
        end else begin
          act_ok_o = 1'b1;
          if (!rrd_ok_i) begin
            viol_o = 1'b1;
            code_o = ERR_RRD;
          end
        end
      end
      CMD_RD, CMD_WR: begin
        if (!open_i[ba_i] || pend_i[ba_i]) begin
          viol_o = 1'b1;
          code_o = ERR_COL_CLOSED;
        end else begin
          col_ok_o = 1'b1;
          if (!rcd_ok_i[ba_i]) begin
            viol_o = 1'b1;
            code_o = ERR_RCD;
          end
        end
      end
      CMD_REF: begin
        if ((|open_i) || !(&rp_ok_i)) begin
          viol_o = 1'b1;
          code_o = ERR_REF;
        end
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/sdram_err_latch.sv
module sdram_err_latch import sdram_mon_pkg::*; (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clr_i,
  input  logic       viol_i,
  input  err_e       code_i,
  output logic       err_o,
  output logic [2:0] code_o
);

  logic       err_q;
  logic [2:0] code_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_q  <= 1'b0;
      code_q <= '0;
    end else if (clr_i) begin
      err_q  <= 1'b0;
      code_q <= '0;
    end else if (viol_i && !err_q) begin
      err_q  <= 1'b1;
      code_q <= code_i;
    end
  end

  assign err_o  = err_q;
  assign code_o = code_q;

endmodule

// File: rtl/sdram_cmd_mon.sv
module sdram_cmd_mon import sdram_mon_pkg::*; #(
  parameter int NB   = 4,
  parameter int TRCD = 3,
  parameter int TRRD = 2,
  parameter int TRP  = 3,
  parameter int BL   = 4
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  clr_i,
  input  logic                  cke_i,
  input  logic                  cs_ni,
  input  logic                  ras_ni,
  input  logic                  cas_ni,
  input  logic                  we_ni,
  input  logic [$clog2(NB)-1:0] ba_i,
  input  logic                  a10_i,
  output logic                  err_o,
  output logic [2:0]            code_o,
  output logic [NB-1:0]         open_o
);

  localparam int BA_W = $clog2(NB);
  localparam int CW   = $clog2(max4(TRCD, TRRD, TRP, BL) + 1);

  cmd_e          cmd;
  logic [NB-1:0] open_w, pend_w, rcd_ok_w, rp_ok_w;
  logic          viol, act_ok, col_ok, rrd_ok;
  err_e          viol_code;
  logic [CW-1:0] rrd_q;
  logic [BA_W-1:0] last_ba_q;

  // command only on an enabled, selected edge
  assign cmd = (cke_i && !cs_ni) ? decode_cmd(ras_ni, cas_ni, we_ni) : CMD_NOP;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rrd_q     <= '0;
      last_ba_q <= '0;
    end else if (cke_i) begin
      if (rrd_q != '0) rrd_q <= rrd_q - 1'b1;
      if (act_ok) begin
        rrd_q     <= CW'(TRRD - 1);
        last_ba_q <= ba_i;
      end
    end
  end

  assign rrd_ok = (rrd_q == '0) || (ba_i == last_ba_q);

  for (genvar b = 0; b < NB; b++) begin : g_bank
    logic sel;
    assign sel = (ba_i == BA_W'(b));
    sdram_bank_trk #(.TRCD(TRCD), .TRP(TRP), .BL(BL), .CW(CW)) u_trk (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .adv_i    (cke_i),
      .act_i    (act_ok && sel),
      .col_i    (col_ok && sel),
      .ap_i     (a10_i),
      .close_i  ((cmd == CMD_PRE) && (a10_i || sel)),
      .open_o   (open_w[b]),
      .pend_o   (pend_w[b]),
      .rcd_ok_o (rcd_ok_w[b]),
      .rp_ok_o  (rp_ok_w[b])
    );
  end

  sdram_rule_eval #(.NB(NB)) u_rules (
    .cmd_i    (cmd),
    .ba_i     (ba_i),
    .open_i   (open_w),
    .pend_i   (pend_w),
    .rcd_ok_i (rcd_ok_w),
    .rp_ok_i  (rp_ok_w),
    .rrd_ok_i (rrd_ok),
    .viol_o   (viol),
    .code_o   (viol_code),
    .act_ok_o (act_ok),
    .col_ok_o (col_ok)
  );

  sdram_err_latch u_err (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr_i),
    .viol_i (viol),
    .code_i (viol_code),
    .err_o  (err_o),
    .code_o (code_o)
  );

  assign open_o = open_w;

endmodule

// File: rtl/sdram_cmd_mon_chk.sv
module sdram_cmd_mon_chk #(
  parameter int NB = 4
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  clr_i,
  input logic                  cke_i,
  input logic                  cs_ni,
  input logic                  ras_ni,
  input logic                  cas_ni,
  input logic                  we_ni,
  input logic [$clog2(NB)-1:0] ba_i,
  input logic                  a10_i,
  input logic                  err_o,
  input logic [2:0]            code_o,
  input logic [NB-1:0]         open_o
);

  logic live;
  assign live = cke_i && !cs_ni;

  assert_clear_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (!err_o && code_o == 3'd0));

  assert_sticky_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_o && !clr_i) |=> (err_o && $stable(code_o)));

  assert_code_set_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (code_o != 3'd0));

  assert_freeze_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cke_i |=> $stable(open_o));

  assert_deselect_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cke_i && cs_ni && !err_o && !clr_i) |=> !err_o);

  assert_pre_all_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live && {ras_ni, cas_ni, we_ni} == 3'b010 && a10_i) |=> (open_o == '0));

  assert_act_opens_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live && {ras_ni, cas_ni, we_ni} == 3'b011 && !open_o[ba_i]) |=> open_o[$past(ba_i)]);

  assert_col_closed_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live && !ras_ni == 1'b0 && !cas_ni && !open_o[ba_i] && !err_o && !clr_i)
      |=> (err_o && code_o == 3'd1));

endmodule

bind sdram_cmd_mon sdram_cmd_mon_chk #(.NB(NB)) u_chk (.*);

// File: tb/sdram_cmd_mon_tb.sv
`timescale 1ns/1ps
module sdram_cmd_mon_tb;

  localparam int NB = 4, TRCD = 3, TRRD = 2, TRP = 3, BL = 4;
  localparam logic [2:0] C_ACT = 3'b011, C_RD = 3'b101, C_WR = 3'b100,
                         C_PRE = 3'b010, C_REF = 3'b001, C_NOP = 3'b111;

  logic clk = 0, rst_n = 0, clr = 0, cke = 1, cs_n = 1;
  logic ras_n = 1, cas_n = 1, we_n = 1, a10 = 0;
  logic [1:0] ba = 0;
  logic err;
  logic [2:0] code;
  logic [NB-1:0] open_b;

  int total = 0, bad = 0;
  bit done = 0;

  // behavioural model state
  int n = 0;
  bit m_open[NB], m_pend[NB];
  int act_t[NB], close_t[NB], close_at[NB];
  int last_act = -1000, last_b = -1;
  bit m_err = 0;
  int m_code = 0;

  always #10 clk = ~clk;

  sdram_cmd_mon #(.NB(NB), .TRCD(TRCD), .TRRD(TRRD), .TRP(TRP), .BL(BL)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .clr_i(clr), .cke_i(cke), .cs_ni(cs_n),
    .ras_ni(ras_n), .cas_ni(cas_n), .we_ni(we_n), .ba_i(ba), .a10_i(a10),
    .err_o(err), .code_o(code), .open_o(open_b));

  function automatic logic [NB-1:0] m_open_vec();
    logic [NB-1:0] v;
    for (int i = 0; i < NB; i++) v[i] = m_open[i];
    return v;
  endfunction

  task automatic check(input string tag);
    total++;
    if (err !== m_err || code !== 3'(m_code) || open_b !== m_open_vec()) begin
      bad++;
      $display("FAIL %s: actual err=%0b code=%0d open=%b expected err=%0b code=%0d open=%b",
               tag, err, code, open_b, m_err, m_code, m_open_vec());
    end
  endtask

  task automatic model(input bit k, input bit c, input logic [2:0] op,
                       input int b, input bit ap, input bit cl);
    bit viol = 0;
    int vc = 0;
    bit any;
    if (!k) return;
    n++;
    if (!c) begin
      case (op)
        C_ACT: if (m_open[b]) begin viol = 1; vc = 2; end
               else begin
                 if (n - last_act < TRRD && b != last_b) begin viol = 1; vc = 5; end
                 m_open[b] = 1; act_t[b] = n; last_act = n; last_b = b;
               end
        C_RD, C_WR: if (!m_open[b] || m_pend[b]) begin viol = 1; vc = 1; end
               else begin
                 if (n - act_t[b] < TRCD) begin viol = 1; vc = 4; end
                 if (ap) begin m_pend[b] = 1; close_at[b] = n + BL; end
               end
        C_PRE: for (int i = 0; i < NB; i++)
                 if ((ap || i == b) && m_open[i]) begin
                   m_open[i] = 0; m_pend[i] = 0; close_t[i] = n;
                 end
        C_REF: begin
                 any = 0;
                 for (int i = 0; i < NB; i++)
                   if (m_open[i] || n - close_t[i] < TRP) any = 1;
                 if (any) begin viol = 1; vc = 3; end
               end
        default: ;
      endcase
    end
    for (int i = 0; i < NB; i++)
      if (m_pend[i] && n == close_at[i] && !(op == C_ACT && !c && i == b && act_t[i] == n)) begin
        m_open[i] = 0; m_pend[i] = 0; close_t[i] = n;
      end
    if (cl) begin m_err = 0; m_code = 0; end
    else if (viol && !m_err) begin m_err = 1; m_code = vc; end
  endtask

  task automatic step(input bit k, input bit c, input logic [2:0] op, input int b,
                      input bit ap, input bit cl, input string tag);
    @(negedge clk);
    cke = k; cs_n = c; {ras_n, cas_n, we_n} = op; ba = 2'(b); a10 = ap; clr = cl;
    @(posedge clk);
    if (cl) begin m_err = 0; m_code = 0; end
    model(k, c, op, b, ap, cl);
    #1 check(tag);
  endtask

  task automatic cmd(input logic [2:0] op, input int b, input bit ap, input string tag);
    step(1, 0, op, b, ap, 0, tag);
  endtask

  task automatic nop(input string tag);
    step(1, 0, C_NOP, 0, 0, 0, tag);
  endtask

  task automatic clear(input string tag);
    step(1, 1, C_NOP, 0, 0, 1, tag);
  endtask

  initial begin
    for (int i = 0; i < NB; i++) begin
      m_open[i] = 0; m_pend[i] = 0; act_t[i] = -1000; close_t[i] = -1000; close_at[i] = -1;
    end
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    #1 check("R13 reset state");

    // R10/R11: column exactly TRCD after activate, column-to-column one apart
    cmd(C_ACT, 0, 0, "R4 activate bank0");
    nop("R10 gap"); nop("R10 gap");
    cmd(C_RD, 0, 0, "R10 read at TRCD");
    cmd(C_WR, 0, 0, "R11 tCCD one edge");
    // R11: activate to another bank one edge after an activate
    cmd(C_ACT, 1, 0, "R11 activate bank1 ok");
    cmd(C_ACT, 2, 0, "R11 tRRD violation code5");
    clear("R12 clear");
    // R5: single-bank then all-bank precharge
    cmd(C_PRE, 1, 0, "R5 precharge one bank");
    cmd(C_PRE, 0, 1, "R5 precharge all");
    cmd(C_PRE, 2, 0, "R5 precharge closed bank");
    // R7 then R12 first-code-kept
    cmd(C_RD, 3, 0, "R7 read closed bank code1");
    cmd(C_ACT, 3, 0, "R12 sticky after activate");
    cmd(C_WR, 3, 0, "R12 first code kept over tRCD");
    clear("R12 clear");
    nop("R10 gap");
    // R8
    cmd(C_ACT, 3, 0, "R8 activate open bank code2");
    clear("R12 clear");
    // R6 auto-precharge
    cmd(C_ACT, 0, 0, "R4 activate bank0");
    nop("R6 gap"); nop("R6 gap");
    cmd(C_RD, 0, 1, "R6 read with auto-precharge");
    cmd(C_RD, 0, 0, "R6 read during auto-close code1");
    clear("R12 clear");
    cmd(C_ACT, 0, 0, "R6 activate during auto-close code2");
    nop("R6 bank closes");
    nop("R6 bank closed");
    clear("R12 clear");
    // R9: refresh with bank open, then too soon after precharge, then at TRP
    cmd(C_REF, 0, 0, "R9 refresh with bank3 open code3");
    clear("R12 clear");
    cmd(C_PRE, 0, 1, "R5 precharge all");
    cmd(C_REF, 0, 0, "R9 refresh inside TRP code3");
    clear("R12 clear");
    nop("R9 gap");
    cmd(C_REF, 0, 0, "R9 refresh at TRP ok");
    // R3: clock enable low freezes counters and ignores commands
    cmd(C_ACT, 1, 0, "R4 activate bank1");
    step(0, 0, C_RD, 2, 0, 0, "R3 read closed bank ignored");
    step(0, 0, C_PRE, 1, 1, 0, "R3 precharge ignored");
    step(0, 0, C_NOP, 0, 0, 0, "R3 frozen");
    cmd(C_RD, 1, 0, "R10 frozen edges not counted code4");
    clear("R12 clear");
    // R2: deselect advances counters
    cmd(C_ACT, 2, 0, "R4 activate bank2");
    step(1, 1, C_RD, 3, 0, 0, "R2 deselected read ignored");
    step(1, 1, C_NOP, 0, 0, 0, "R2 deselect");
    cmd(C_WR, 2, 0, "R2 counters advanced, write ok");
    // R1: non-commands
    cmd(3'b000, 0, 0, "R1 mode set no effect");
    cmd(3'b110, 0, 0, "R1 burst stop no effect");
    // R12: clear wins over a same-edge violation
    step(1, 0, C_RD, 0, 0, 1, "R12 clear wins");
    nop("R12 still clear");
    cmd(C_WR, 3, 0, "R7 write closed bank code1");
    nop("R12 held");
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule